// File: doc/BRIEF.md
# Double-Buffered Serial Gain Control Port

This block is the control side of a programmable-gain output stage. A host writes it over a three-wire serial link made of a clock, a data line and an active-low select. Each write is a 12-bit word. The upper four bits choose a register and the lower eight bits carry its data. The serial pins are brought into the system clock domain through two-flop synchronizers, and every edge is detected in that domain. For this to work, the serial clock must run at no more than a quarter of the system clock rate.

A write to the power/gain register does not change the outputs directly. It lands in a shadow copy. The shadow copy moves to the active power and gain outputs only when the transmit-enable input falls from high to low, so a new setting never appears in the middle of a burst. For a fixed interval after reset, a lockout counter rejects every write.

The block also reports transmit mode, which follows transmit enable, and an output-stage power-down flag, which is the complement of transmit mode.

Top module: `sgc_ctrl`

## Requirements
- R1: Synchronous reset sets `pwr_code` and `gain_code` to zero, `tx_mode` to 0 and `out_pdn` to 1.
- R2: A frame is 12 bits, sent most significant bit first, with one bit sampled on each rising serial-clock edge while the select is low. Bits 11:8 are the address and bits 7:0 are the data. For address 0, data bits 7:6 are the power code and data bits 5:0 are the gain code. Every pairing of power code (0 to 3) and gain code (0 to 63) can be written.
- R3: The active `pwr_code` and `gain_code` change only on a high-to-low transition of `tx_en`, and at that point they take the last shadow value. A write made while `tx_en` is low or high leaves them unchanged until the next fall.
- R4: A frame that completes fewer than CLK_MHZ × LOCK_US system cycles after reset is discarded.
- R5: A frame is committed only if exactly 12 rising serial-clock edges occur while the select is low. With 11 or 13 edges, no register changes.
- R6: Frames to addresses 2 through 15 change no register.
- R7: A frame to address 1 clears the shadow power/gain register to zero, whatever its data byte holds.
- R8: `tx_mode` follows `tx_en` after synchronization, and `out_pdn` is its complement.
- R9: Lowering the select clears the bit count, so a select pulse that is abandoned part-way leaves no trace in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Serial clock; data is sampled on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_csn | input | 1 | Active-low frame select |
| tx_en | input | 1 | Transmit enable; its falling edge applies the shadow settings |
| pwr_code | output | 2 | Active power code |
| gain_code | output | 6 | Active gain code, 1 dB per step |
| tx_mode | output | 1 | High while transmitting |
| out_pdn | output | 1 | Output-stage power-down, high while not transmitting |

## Verification
The bench builds the block with CLK_MHZ = 250 and LOCK_US = 1. This cuts the power-up lockout to 250 cycles, so one frame can be sent while the lockout is still running and then checked for rejection. The shortened lockout also leaves room, well inside the run limit, to sweep all 256 combinations of power code and gain code. Each combination is checked at three points: before, during and after a transmit burst. Malformed frames of 11 and 13 bits, undefined addresses, the clear-on-initialize write and an abandoned partial frame are checked afterwards against the value the bench holds in its own model.

// File: rtl/sgc_pkg.sv
package sgc_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 8;
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int PWR_W   = 2;
  localparam int GAIN_W  = DATA_W - PWR_W;

  localparam logic [ADDR_W-1:0] ADR_PWRGAIN = 4'd0;
  localparam logic [ADDR_W-1:0] ADR_INIT    = 4'd1;

  typedef struct packed {
    logic [PWR_W-1:0]  pwr;
    logic [GAIN_W-1:0] gain;
  } pg_t;
endpackage

// File: rtl/sgc_sync.sv
module sgc_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= RST_VAL;
      else     stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sgc_lockout.sv
module sgc_lockout #(
  parameter int LOCK_CYCLES = 25000
) (
  input  logic clk,
  input  logic rst,
  output logic ready
);
  localparam int LW = $clog2(LOCK_CYCLES + 1);
  localparam logic [LW-1:0] LAST = LW'(LOCK_CYCLES - 1);

  logic [LW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else if (!ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == LAST) ready <= 1'b1;
    end
  end

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready); // R4
endmodule

// File: rtl/sgc_frame_rx.sv
module sgc_frame_rx
  import sgc_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               sclk_s,
  input  logic               dat_s,
  input  logic               csn_s,
  output logic               frame_vld,
  output logic [FRAME_W-1:0] frame_word
);
  localparam int CW = $clog2(FRAME_W + 2);
  localparam logic [CW-1:0] FULL = CW'(FRAME_W);
  localparam logic [CW-1:0] SAT  = CW'(FRAME_W + 1);

  logic          sclk_q, csn_q;
  logic [CW-1:0] cnt;
  logic          csn_fall, csn_rise, sclk_rise;

  assign csn_fall  = csn_q & ~csn_s;
  assign csn_rise  = ~csn_q & csn_s;
  assign sclk_rise = ~sclk_q & sclk_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q     <= 1'b0;
      csn_q      <= 1'b1;
      cnt        <= '0;
      frame_word <= '0;
      frame_vld  <= 1'b0;
    end else begin
      sclk_q    <= sclk_s;
      csn_q     <= csn_s;
      frame_vld <= 1'b0;
      if (csn_fall) begin
        cnt        <= '0;
        frame_word <= '0;
      end else if (!csn_s && sclk_rise) begin
        frame_word <= {frame_word[FRAME_W-2:0], dat_s};
        if (cnt != SAT) cnt <= cnt + 1'b1;
      end
      if (csn_rise && cnt == FULL) frame_vld <= 1'b1;
    end
  end

  AST_VLD_DESELECTED: assert property (@(posedge clk) disable iff (rst)
    frame_vld |-> csn_s); // R5
  AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_vld |=> !frame_vld); // R5
endmodule

// File: rtl/sgc_ctrl.sv
module sgc_ctrl
  import sgc_pkg::*;
#(
  parameter int CLK_MHZ = 250,
  parameter int LOCK_US = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              ser_csn,
  input  logic              tx_en,
  output logic [PWR_W-1:0]  pwr_code,
  output logic [GAIN_W-1:0] gain_code,
  output logic              tx_mode,
  output logic              out_pdn
);
  localparam int LOCK_CYCLES = CLK_MHZ * LOCK_US;

  logic [3:0]         sync_q;
  logic               sclk_s, dat_s, csn_s, txen_s;
  logic               ready;
  logic               frame_vld;
  logic [FRAME_W-1:0] frame_word;
  logic [ADDR_W-1:0]  f_addr;
  logic [DATA_W-1:0]  f_data;
  logic               txen_q, tx_fall, commit;
  pg_t                shadow, active;

  sgc_sync #(.W(4), .STAGES(2), .RST_VAL(4'b0100)) u_sync (
    .clk(clk), .rst(rst),
    .d({tx_en, ser_csn, ser_dat, ser_clk}),
    .q(sync_q)
  );
  assign {txen_s, csn_s, dat_s, sclk_s} = sync_q;

  sgc_lockout #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .rst(rst), .ready(ready)
  );

  sgc_frame_rx u_rx (
    .clk(clk), .rst(rst),
    .sclk_s(sclk_s), .dat_s(dat_s), .csn_s(csn_s),
    .frame_vld(frame_vld), .frame_word(frame_word)
  );

  assign f_addr  = frame_word[FRAME_W-1:DATA_W];
  assign f_data  = frame_word[DATA_W-1:0];
  assign commit  = frame_vld & ready;
  assign tx_fall = txen_q & ~txen_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
    end else if (commit) begin
      case (f_addr)
        ADR_PWRGAIN: shadow <= pg_t'(f_data);
        ADR_INIT:    shadow <= '0;
        default:     shadow <= shadow;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txen_q  <= 1'b0;
      active  <= '0;
      tx_mode <= 1'b0;
      out_pdn <= 1'b1;
    end else begin
      txen_q  <= txen_s;
      tx_mode <= txen_s;
      out_pdn <= ~txen_s;
      if (tx_fall) active <= shadow;
    end
  end

  assign pwr_code  = active.pwr;
  assign gain_code = active.gain;

  AST_LOCKOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !ready |=> $stable(shadow)); // R4
  AST_ACTIVE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    !tx_fall |=> $stable(active)); // R3
  AST_BAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    (frame_vld && f_addr > ADR_INIT) |=> $stable(shadow)); // R6
  AST_INIT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (commit && f_addr == ADR_INIT) |=> (shadow == '0)); // R7
  AST_PDN_COMPL: assert property (@(posedge clk) disable iff (rst)
    out_pdn == !tx_mode); // R8
endmodule

// File: tb/tb_sgc_ctrl.sv
module tb_sgc_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_csn = 1'b1, tx_en = 1'b0;
  logic [1:0] pwr_code;
  logic [5:0] gain_code;
  logic tx_mode, out_pdn;
  int n_run = 0, n_fail = 0;
  logic [7:0] exp_act = 8'h00;

  always #2 clk = ~clk;

  sgc_ctrl #(.CLK_MHZ(250), .LOCK_US(1)) dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
    .ser_csn(ser_csn), .tx_en(tx_en), .pwr_code(pwr_code),
    .gain_code(gain_code), .tx_mode(tx_mode), .out_pdn(out_pdn)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic send_bits(input int n, input logic [15:0] w);
    ser_csn = 1'b0;
    wait_n(8);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = w[i];
      wait_n(4);
      ser_clk = 1'b1;
      wait_n(4);
      ser_clk = 1'b0;
    end
    wait_n(4);
    ser_csn = 1'b1;
    wait_n(8);
  endtask

  task automatic tx_pulse();
    tx_en = 1'b1;
    wait_n(8);
    tx_en = 1'b0;
    wait_n(8);
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_n(5);
    rst = 1'b0;
    wait_n(1);
    // R1 reset state
    chk("R1 codes", {pwr_code, gain_code}, 8'h00);
    chk("R1 tx_mode", {7'd0, tx_mode}, 8'h00);
    chk("R1 out_pdn", {7'd0, out_pdn}, 8'h01);
    // R4 frame inside lockout is dropped
    send_bits(12, {4'h0, 4'h0, 8'hFF});
    tx_pulse();
    chk("R4 lockout", {pwr_code, gain_code}, 8'h00);
    wait_n(300);
    // R2 R3 R8 full sweep
    for (int p = 0; p < 4; p++) begin
      for (int g = 0; g < 64; g++) begin
        logic [7:0] nv;
        nv = {p[1:0], g[5:0]};
        send_bits(12, {4'h0, 4'h0, nv});
        chk("R3 held before fall", {pwr_code, gain_code}, exp_act);
        tx_en = 1'b1;
        wait_n(8);
        chk("R8 tx_mode high", {7'd0, tx_mode}, 8'h01);
        chk("R8 out_pdn low", {7'd0, out_pdn}, 8'h00);
        chk("R3 held while high", {pwr_code, gain_code}, exp_act);
        tx_en = 1'b0;
        wait_n(8);
        exp_act = nv;
        chk("R2 applied on fall", {pwr_code, gain_code}, exp_act);
        chk("R8 out_pdn high", {7'd0, out_pdn}, 8'h01);
      end
    end
    // R5 wrong lengths
    send_bits(11, {5'd0, 3'b000, 8'h12});
    tx_pulse();
    chk("R5 11 bits", {pwr_code, gain_code}, exp_act);
    send_bits(13, {3'd0, 1'b0, 4'h0, 8'h34});
    tx_pulse();
    chk("R5 13 bits", {pwr_code, gain_code}, exp_act);
    // R6 undefined addresses
    for (int a = 2; a < 16; a++) begin
      send_bits(12, {4'h0, a[3:0], 8'h5A});
      tx_pulse();
      chk("R6 bad address", {pwr_code, gain_code}, exp_act);
    end
    // R7 initialize clears shadow
    send_bits(12, {4'h0, 4'h0, 8'h55});
    send_bits(12, {4'h0, 4'h1, 8'hA5});
    tx_pulse();
    exp_act = 8'h00;
    chk("R7 init clear", {pwr_code, gain_code}, exp_act);
    // R9 abandoned partial frame
    send_bits(12, {4'h0, 4'h0, 8'h81});
    tx_pulse();
    exp_act = 8'h81;
    send_bits(5, 16'h001F);
    tx_pulse();
    chk("R9 partial dropped", {pwr_code, gain_code}, exp_act);
    send_bits(12, {4'h0, 4'h0, 8'h3C});
    tx_pulse();
    exp_act = 8'h3C;
    chk("R9 next frame clean", {pwr_code, gain_code}, exp_act);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule